// File: doc/BRIEF.md
# Address Translation Cache with Whole-Table Invalidation

This block keeps recently used virtual-page-to-physical-frame translations, each with a writable bit and a user-access bit. A lookup presents a 20-bit virtual page number together with the access kind (read or write) and the privilege (user or supervisor). In the same cycle, the block returns the frame number, the stored permission bits, and either a hit or a request to the page walker. A hit whose stored permissions forbid the access raises a protection fault.

The walker is outside this block. It answers a request by presenting a fill, and the block installs that fill in its table. When the fill's page number is already present, the block overwrites that entry. Otherwise it places the fill in the slot named by a round-robin pointer.

The only control is a write to the directory base register. That write loads the register and invalidates every entry at once. No single entry can be dropped on its own.

Top module: `xlat_cache`

## Requirements
- R1: After reset, every entry is invalid, every lookup misses, and `dir_base` reads 0.
- R2: A lookup (`lk_valid`=1) whose page number matches a valid entry sets `lk_hit` in the same cycle. In that cycle `lk_pfn`, `lk_wr_perm` and `lk_usr_perm` carry that entry's frame and bits. When there is no hit, all three read 0.
- R3: A lookup that does not hit sets `walk_req`=1 with `walk_vpn` equal to `lk_vpn`, and `lk_hit`=0.
- R4: A fill (`fill_valid`=1) is visible to lookups from the cycle after it is presented.
- R5: On a hit, `lk_fault`=1 when `lk_write`=1 and the entry's writable bit is 0, or when `lk_user`=1 and the entry's user bit is 0. `lk_hit` stays 1 in that case. `lk_fault` is 0 on every miss.
- R6: A cycle with `base_wr`=1 loads `base_val` into `dir_base`, visible from the next cycle. From that next cycle, every earlier entry misses.
- R7: A lookup in the same cycle as `base_wr`=1 misses and requests a walk. A fill in that same cycle is discarded.
- R8: The replacement pointer starts at slot 0 after reset or a base write. It advances by one for each fill of a new page number and wraps after slot 63. As a result, the 65th distinct fill after a base write evicts the first one, and the others remain.
- R9: A fill whose page number is already present overwrites that entry in place and does not advance the replacement pointer.
- R10: With `lk_valid`=0, `lk_hit`, `lk_fault` and `walk_req` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup present |
| lk_vpn | input | 20 | Virtual page number to translate |
| lk_write | input | 1 | Access is a write |
| lk_user | input | 1 | Access is made at user privilege |
| lk_hit | output | 1 | Translation found |
| lk_pfn | output | 20 | Physical frame on hit, else 0 |
| lk_wr_perm | output | 1 | Entry writable bit on hit, else 0 |
| lk_usr_perm | output | 1 | Entry user bit on hit, else 0 |
| lk_fault | output | 1 | Hit whose permissions forbid the access |
| walk_req | output | 1 | Miss: request to the page walker |
| walk_vpn | output | 20 | Page number for the walker |
| fill_valid | input | 1 | Walker returns an entry |
| fill_vpn | input | 20 | Page number of the returned entry |
| fill_pfn | input | 20 | Frame of the returned entry |
| fill_wr | input | 1 | Writable bit of the returned entry |
| fill_usr | input | 1 | User bit of the returned entry |
| base_wr | input | 1 | Write to the directory base register (flushes all entries) |
| base_val | input | 20 | Value written to the directory base register |
| dir_base | output | 20 | Current directory base register |

## Verification
All lookup results (hit, frame, attributes, fault and walk request) are combinational from the table, so they are due in the same cycle as the lookup. Fills, the flush and the `dir_base` load each take effect one rising edge after they are presented. To match this, the bench drives every input on the falling edge and samples the outputs one nanosecond later, before the next rising edge. It updates its reference table only after that rising edge. As a result, a fill or flush is never expected before the cycle in which it can first be seen.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
    localparam int unsigned VPN_W = 20;
    localparam int unsigned PFN_W = 20;

    typedef struct packed {
        logic             vld;
        logic [VPN_W-1:0] vpn;
        logic [PFN_W-1:0] pfn;
        logic             wr;
        logic             usr;
    } xlat_ent_t;
endpackage

// File: rtl/xlat_entry_store.sv
module xlat_entry_store
    import xlat_pkg::*;
#(
    parameter int unsigned ENTRIES = 64,
    localparam int unsigned IDX_W = $clog2(ENTRIES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               flush,
    input  logic               wr_en,
    input  logic [IDX_W-1:0]   wr_idx,
    input  xlat_ent_t          wr_ent,
    input  logic [VPN_W-1:0]   lk_vpn,
    input  logic [VPN_W-1:0]   fl_vpn,
    output logic [ENTRIES-1:0] lk_match,
    output xlat_ent_t          lk_ent,
    output logic               fl_any,
    output logic [IDX_W-1:0]   fl_idx
);
    xlat_ent_t ents_d [ENTRIES];
    xlat_ent_t ents_q [ENTRIES];
    logic [ENTRIES-1:0] fl_match;

    // next state: a flush wins over a write in the same cycle
    always_comb begin
        for (int i = 0; i < ENTRIES; i++) begin
            ents_d[i] = ents_q[i];
            if (flush) begin
                ents_d[i].vld = 1'b0;
            end else if (wr_en && (wr_idx == IDX_W'(i))) begin
                ents_d[i] = wr_ent;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) begin
                ents_q[i] <= '0;
            end
        end else begin
            for (int i = 0; i < ENTRIES; i++) begin
                ents_q[i] <= ents_d[i];
            end
        end
    end

    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign lk_match[g] = ents_q[g].vld && (ents_q[g].vpn == lk_vpn);
        assign fl_match[g] = ents_q[g].vld && (ents_q[g].vpn == fl_vpn);
    end

    always_comb begin
        lk_ent = '0;
        fl_idx = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (lk_match[i]) lk_ent = lk_ent | ents_q[i];
            if (fl_match[i]) fl_idx = fl_idx | IDX_W'(i);
        end
    end

    assign fl_any = |fl_match;
endmodule

// File: rtl/xlat_victim_ptr.sv
module xlat_victim_ptr #(
    parameter int unsigned ENTRIES = 64,
    localparam int unsigned IDX_W = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             advance,
    output logic [IDX_W-1:0] ptr
);
    logic [IDX_W-1:0] ptr_d, ptr_q;

    always_comb begin
        ptr_d = ptr_q;
        if (clear) begin
            ptr_d = '0;
        end else if (advance) begin
            ptr_d = (ptr_q == IDX_W'(ENTRIES - 1)) ? '0 : ptr_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ptr_q <= '0;
        else        ptr_q <= ptr_d;
    end

    assign ptr = ptr_q;
endmodule

// File: rtl/xlat_perm_chk.sv
module xlat_perm_chk (
    input  logic ent_wr,
    input  logic ent_usr,
    input  logic acc_write,
    input  logic acc_user,
    output logic deny
);
    always_comb begin
        deny = (acc_write && !ent_wr) || (acc_user && !ent_usr);
    end
endmodule

// File: rtl/xlat_cache.sv
module xlat_cache
    import xlat_pkg::*;
#(
    parameter int unsigned ENTRIES = 64,
    localparam int unsigned IDX_W = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lk_valid,
    input  logic [VPN_W-1:0] lk_vpn,
    input  logic             lk_write,
    input  logic             lk_user,
    output logic             lk_hit,
    output logic [PFN_W-1:0] lk_pfn,
    output logic             lk_wr_perm,
    output logic             lk_usr_perm,
    output logic             lk_fault,
    output logic             walk_req,
    output logic [VPN_W-1:0] walk_vpn,
    input  logic             fill_valid,
    input  logic [VPN_W-1:0] fill_vpn,
    input  logic [PFN_W-1:0] fill_pfn,
    input  logic             fill_wr,
    input  logic             fill_usr,
    input  logic             base_wr,
    input  logic [PFN_W-1:0] base_val,
    output logic [PFN_W-1:0] dir_base
);
    typedef struct packed {
        logic [PFN_W-1:0] dir_base;
    } top_st_t;

    top_st_t st_d, st_q;

    logic [ENTRIES-1:0] lk_match_vec;
    xlat_ent_t          lk_ent;
    xlat_ent_t          new_ent;
    logic               fl_any;
    logic [IDX_W-1:0]   fl_idx;
    logic [IDX_W-1:0]   victim;
    logic [IDX_W-1:0]   wr_idx;
    logic               wr_en;
    logic               adv;
    logic               deny;
    logic               hit_raw;

    always_comb begin
        st_d = st_q;
        if (base_wr) st_d.dir_base = base_val;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        new_ent.vld = 1'b1;
        new_ent.vpn = fill_vpn;
        new_ent.pfn = fill_pfn;
        new_ent.wr  = fill_wr;
        new_ent.usr = fill_usr;
        wr_en  = fill_valid && !base_wr;
        wr_idx = fl_any ? fl_idx : victim;
        adv    = wr_en && !fl_any;
    end

    xlat_entry_store #(.ENTRIES(ENTRIES)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .flush    (base_wr),
        .wr_en    (wr_en),
        .wr_idx   (wr_idx),
        .wr_ent   (new_ent),
        .lk_vpn   (lk_vpn),
        .fl_vpn   (fill_vpn),
        .lk_match (lk_match_vec),
        .lk_ent   (lk_ent),
        .fl_any   (fl_any),
        .fl_idx   (fl_idx)
    );

    xlat_victim_ptr #(.ENTRIES(ENTRIES)) u_ptr (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (base_wr),
        .advance (adv),
        .ptr     (victim)
    );

    xlat_perm_chk u_perm (
        .ent_wr    (lk_ent.wr),
        .ent_usr   (lk_ent.usr),
        .acc_write (lk_write),
        .acc_user  (lk_user),
        .deny      (deny)
    );

    always_comb begin
        hit_raw     = |lk_match_vec;
        lk_hit      = lk_valid && !base_wr && hit_raw;
        lk_pfn      = lk_hit ? lk_ent.pfn : '0;
        lk_wr_perm  = lk_hit && lk_ent.wr;
        lk_usr_perm = lk_hit && lk_ent.usr;
        lk_fault    = lk_hit && deny;
        walk_req    = lk_valid && !lk_hit;
        walk_vpn    = lk_vpn;
        dir_base    = st_q.dir_base;
    end
endmodule

// File: rtl/xlat_cache_chk.sv
module xlat_cache_chk #(
    parameter int unsigned ENTRIES = 64
) (
    input logic               clk,
    input logic               rst_n,
    input logic               lk_valid,
    input logic [19:0]        lk_vpn,
    input logic               lk_hit,
    input logic [19:0]        lk_pfn,
    input logic               lk_fault,
    input logic               walk_req,
    input logic               fill_valid,
    input logic [19:0]        fill_vpn,
    input logic [19:0]        fill_pfn,
    input logic               base_wr,
    input logic [19:0]        base_val,
    input logic [19:0]        dir_base,
    input logic [ENTRIES-1:0] match_vec
);
    // R9
    one_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(match_vec));

    // R5
    fault_needs_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lk_fault |-> lk_hit);

    // R3
    walk_on_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
        walk_req |-> (lk_valid && !lk_hit));

    // R10
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |-> (!lk_hit && !walk_req && !lk_fault));

    // R7
    flush_same_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        base_wr |-> !lk_hit);

    // R6
    flush_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        base_wr |=> !lk_hit);

    // R6
    base_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        base_wr |=> (dir_base == $past(base_val)));

    // R4
    fill_visible_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_valid && !base_wr) |=>
            ((lk_valid && !base_wr && lk_vpn == $past(fill_vpn)) |->
                (lk_hit && lk_pfn == $past(fill_pfn))));
endmodule

bind xlat_cache xlat_cache_chk #(.ENTRIES(ENTRIES)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .lk_valid   (lk_valid),
    .lk_vpn     (lk_vpn),
    .lk_hit     (lk_hit),
    .lk_pfn     (lk_pfn),
    .lk_fault   (lk_fault),
    .walk_req   (walk_req),
    .fill_valid (fill_valid),
    .fill_vpn   (fill_vpn),
    .fill_pfn   (fill_pfn),
    .base_wr    (base_wr),
    .base_val   (base_val),
    .dir_base   (dir_base),
    .match_vec  (lk_match_vec)
);

// File: tb/sim_xlat_cache.sv
module sim_xlat_cache;
    localparam int CLK_NS = 10;
    localparam int N = 64;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic lk_valid = 0, lk_write = 0, lk_user = 0;
    logic [19:0] lk_vpn = '0;
    logic lk_hit, lk_wr_perm, lk_usr_perm, lk_fault, walk_req;
    logic [19:0] lk_pfn, walk_vpn, dir_base;
    logic fill_valid = 0, fill_wr = 0, fill_usr = 0;
    logic [19:0] fill_vpn = '0, fill_pfn = '0;
    logic base_wr = 0;
    logic [19:0] base_val = '0;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    logic        m_vld [N];
    logic [19:0] m_vpn [N];
    logic [19:0] m_pfn [N];
    logic        m_wr  [N];
    logic        m_usr [N];
    int          m_ptr;
    logic [19:0] m_dir;

    always #(CLK_NS/2) clk = ~clk;

    xlat_cache u0 (
        .clk(clk), .rst_n(rst_n),
        .lk_valid(lk_valid), .lk_vpn(lk_vpn), .lk_write(lk_write), .lk_user(lk_user),
        .lk_hit(lk_hit), .lk_pfn(lk_pfn), .lk_wr_perm(lk_wr_perm), .lk_usr_perm(lk_usr_perm),
        .lk_fault(lk_fault), .walk_req(walk_req), .walk_vpn(walk_vpn),
        .fill_valid(fill_valid), .fill_vpn(fill_vpn), .fill_pfn(fill_pfn),
        .fill_wr(fill_wr), .fill_usr(fill_usr),
        .base_wr(base_wr), .base_val(base_val), .dir_base(dir_base)
    );

    task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    function automatic int find(logic [19:0] v);
        for (int i = 0; i < N; i++) if (m_vld[i] && m_vpn[i] == v) return i;
        return -1;
    endfunction

    task automatic model_clear();
        for (int i = 0; i < N; i++) begin
            m_vld[i] = 0; m_vpn[i] = '0; m_pfn[i] = '0; m_wr[i] = 0; m_usr[i] = 0;
        end
        m_ptr = 0;
    endtask

    // one cycle: drive at falling edge, check before rising edge, update model after it
    task automatic step(string tag, logic lv, logic [19:0] v, logic w, logic u,
                        logic fv, logic [19:0] fvp, logic [19:0] fpf, logic fw, logic fu,
                        logic bw, logic [19:0] bv);
        int idx;
        logic e_hit, e_fault;
        logic [19:0] e_pfn;
        @(negedge clk);
        lk_valid = lv; lk_vpn = v; lk_write = w; lk_user = u;
        fill_valid = fv; fill_vpn = fvp; fill_pfn = fpf; fill_wr = fw; fill_usr = fu;
        base_wr = bw; base_val = bv;
        #1;
        idx = find(v);
        e_hit = lv && !bw && (idx >= 0);
        e_pfn = e_hit ? m_pfn[idx] : '0;
        e_fault = e_hit && ((w && !m_wr[idx]) || (u && !m_usr[idx]));
        chk(tag, "hit", 32'(lk_hit), 32'(e_hit));
        chk(tag, "pfn", 32'(lk_pfn), 32'(e_pfn));
        chk(tag, "wr_perm", 32'(lk_wr_perm), 32'(e_hit && m_wr[idx]));
        chk(tag, "usr_perm", 32'(lk_usr_perm), 32'(e_hit && m_usr[idx]));
        chk(tag, "fault", 32'(lk_fault), 32'(e_fault));
        chk(tag, "walk_req", 32'(walk_req), 32'(lv && !e_hit));
        if (lv && !e_hit) chk(tag, "walk_vpn", 32'(walk_vpn), 32'(v));
        chk(tag, "dir_base", 32'(dir_base), 32'(m_dir));
        @(posedge clk);
        if (bw) begin
            model_clear();
            m_dir = bv;
        end else if (fv) begin
            idx = find(fvp);
            if (idx < 0) begin
                idx = m_ptr;
                m_ptr = (m_ptr == N - 1) ? 0 : m_ptr + 1;
            end
            m_vld[idx] = 1; m_vpn[idx] = fvp; m_pfn[idx] = fpf;
            m_wr[idx] = fw; m_usr[idx] = fu;
        end
    endtask

    task automatic look(string tag, logic [19:0] v, logic w, logic u);
        step(tag, 1, v, w, u, 0, '0, '0, 0, 0, 0, '0);
    endtask

    task automatic fill(string tag, logic [19:0] v, logic [19:0] p, logic w, logic u);
        step(tag, 0, '0, 0, 0, 1, v, p, w, u, 0, '0);
    endtask

    initial begin
        #(CLK_NS * 200000);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd24680));
        model_clear();
        m_dir = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: empty after reset
        look("R1", 20'h00000, 0, 0);
        look("R1", 20'h12345, 0, 1);

        // R4 then R2: install and hit
        fill("R4", 20'h12345, 20'hABCDE, 0, 1);
        look("R2", 20'h12345, 0, 1);
        // R5: write to a read-only page faults
        look("R5", 20'h12345, 1, 0);
        fill("R4", 20'h00777, 20'h00101, 1, 0);
        // R5: user access to a supervisor page faults
        look("R5", 20'h00777, 0, 1);
        look("R5", 20'h00777, 1, 0);
        // R3: miss requests the walker
        look("R3", 20'h00778, 1, 1);
        // R10: idle lookup
        step("R10", 0, 20'h12345, 1, 1, 0, '0, '0, 0, 0, 0, '0);

        // R7: lookup during the base write misses
        step("R7", 1, 20'h12345, 0, 0, 0, '0, '0, 0, 0, 1, 20'h5A5A5);
        // R6: everything gone, base loaded
        look("R6", 20'h12345, 0, 0);
        look("R6", 20'h00777, 0, 0);
        // R7: fill in the base-write cycle is dropped
        step("R7", 0, '0, 0, 0, 1, 20'h00042, 20'h00099, 1, 1, 1, 20'h0C0DE);
        look("R7", 20'h00042, 0, 0);

        // R8: 65 distinct fills after a flush, the first is evicted
        step("R8", 0, '0, 0, 0, 0, '0, '0, 0, 0, 1, 20'h00001);
        for (int i = 0; i < N + 1; i++) fill("R8", 20'h00100 + 20'(i), 20'h30000 + 20'(i), 1, 1);
        look("R8", 20'h00100, 0, 0);
        look("R8", 20'h00101, 0, 0);
        look("R8", 20'h00140, 0, 0);

        // R9: refill in place keeps the pointer
        fill("R9", 20'h00105, 20'h7FFFF, 0, 0);
        look("R9", 20'h00105, 1, 1);
        fill("R9", 20'h00200, 20'h00200, 1, 1);
        look("R9", 20'h00101, 0, 0);
        look("R9", 20'h00102, 0, 0);

        // randomized traffic over a pool larger than the table
        for (int k = 0; k < 4000; k++) begin
            logic [19:0] v, fvp;
            v   = 20'($urandom_range(0, 79));
            fvp = 20'($urandom_range(0, 79));
            step("RAND_R2_R3_R5", 1'($urandom_range(0, 3) != 0), v,
                 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                 1'($urandom_range(0, 2) == 0), fvp, 20'($urandom),
                 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                 1'($urandom_range(0, 99) < 2), 20'($urandom));
        end

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule